// File: doc/BRIEF.md
# AXI Data Channel Parity Checker

This block watches an AXI4 write-data channel and an AXI4 read-data channel and checks byte parity on every beat that completes a handshake. Each data byte has one parity bit, carried in that channel's user sideband at a fixed stride. When any checked byte disagrees with its parity bit, the block raises a one-cycle error pulse for that channel. It only listens: every AXI signal is an input, and it never stalls or changes traffic.

Each channel is configured at elaboration for even parity, odd parity or no checking. A test input per channel forces an error pulse on a handshake, so the error path can be proven in the field. A bit mask parameter places optional registers along the error path. This trades output latency for timing slack after the wide XOR trees.

Top module: `axi_beat_parity_check`

## Requirements
- R1: Byte lane i (bits 8i+7..8i of the data) is bad when the XOR of its eight data bits, XOR the user bit at index i times the channel's stride, XOR 1 in odd mode, equals 1. The stride is 1 for write and 2 for read in the default configuration. User bits at other indices have no effect.
- R2: On the write channel, lane i is checked only when write strobe bit i is 1. A bad lane with a clear strobe bit raises no error.
- R3: On the read channel, every lane is checked on every beat, with no masking.
- R4: A beat counts only when valid, ready and the clock enable are all 1. Each counted beat drives exactly one output cycle, high when any checked lane is bad and low otherwise. The output does not stay high for later cycles.
- R5: While a channel's inject input is 1, every counted beat on that channel produces an error pulse, whatever its parity. This includes a channel whose checking is disabled.
- R6: A channel configured with checking disabled never reports a parity error. Only injection can pulse its output.
- R7: The error output lags the beat's handshake cycle by as many clock-enabled cycles as there are set bits in the pipelining mask. With a mask of zero, the output appears in the handshake cycle itself.
- R8: While the clock enable is 0, no beat is counted and the pipeline registers hold their contents.
- R9: While the active-low reset is 0, both error outputs are 0. Nothing from before reset appears after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aclken | input | 1 | Clock enable for beat counting and pipeline stages |
| aresetn | input | 1 | Active-low reset |
| wData | input | DATA_WIDTH | Write data |
| wStrb | input | DATA_WIDTH/8 | Write byte strobes |
| wUser | input | WUSER_WIDTH | Write user sideband carrying parity bits |
| wValid | input | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| rData | input | DATA_WIDTH | Read data |
| rUser | input | RUSER_WIDTH | Read user sideband carrying parity bits |
| rValid | input | 1 | Read data valid |
| rReady | input | 1 | Read data ready |
| wInject | input | 1 | Force an error on write handshakes |
| rInject | input | 1 | Force an error on read handshakes |
| wParityErr | output | 1 | Write parity error pulse |
| rParityErr | output | 1 | Read parity error pulse |

## Verification
The hardest case to reach from the ports is a beat that falls inside a delayed pipeline while the clock enable drops. In that case an earlier pulse must sit frozen in a register while new handshakes are ignored. The stimulus toggles the clock enable at random during a long run of beats with random parity and strobes. A bench model advances its own delay line only on enabled cycles. Two instances run at once, one pipelined with even and odd checking and one unregistered with the read channel disabled. This exposes latency and mode faults on every beat.

// File: rtl/axi_parity_pkg.sv
package axi_parity_pkg;

  typedef enum logic [1:0] {
    PAR_OFF  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2
  } parMode_e;

  typedef struct packed {
    logic wFire;
    logic rFire;
    logic wForce;
    logic rForce;
    logic advance;
  } parStrobes_t;

endpackage

// File: rtl/parity_ctrl.sv
module parity_ctrl
  import axi_parity_pkg::*;
(
  input  logic        aresetn,
  input  logic        aclken,
  input  logic        wValid,
  input  logic        wReady,
  input  logic        rValid,
  input  logic        rReady,
  input  logic        wInject,
  input  logic        rInject,
  output parStrobes_t strobes
);

  always_comb begin
    strobes.advance = aclken;
    strobes.wFire   = aresetn & aclken & wValid & wReady;
    strobes.rFire   = aresetn & aclken & rValid & rReady;
    strobes.wForce  = wInject;
    strobes.rForce  = rInject;
  end

endmodule

// File: rtl/parity_pipe.sv
module parity_pipe #(
  parameter int              PIPE_W    = 4,
  parameter logic [PIPE_W-1:0] PIPE_MASK = '0
) (
  input  logic aclk,
  input  logic aresetn,
  input  logic advance,
  input  logic din,
  output logic dout
);

  logic [PIPE_W:0] chain;

  assign chain[0] = din;

  for (genvar k = 0; k < PIPE_W; k++) begin : g_stage
    if (PIPE_MASK[k]) begin : g_reg
      logic stageQ;
      always_ff @(posedge aclk or negedge aresetn) begin
        if (!aresetn)     stageQ <= 1'b0;
        else if (advance) stageQ <= chain[k];
      end
      assign chain[k+1] = stageQ;
    end else begin : g_wire
      assign chain[k+1] = chain[k];
    end
  end

  assign dout = chain[PIPE_W];

endmodule

// File: rtl/parity_dp.sv
module parity_dp
  import axi_parity_pkg::*;
#(
  parameter int                DATA_WIDTH  = 32,
  parameter int                WUSER_WIDTH = 4,
  parameter int                RUSER_WIDTH = 8,
  parameter int                W_STRIDE    = 1,
  parameter int                R_STRIDE    = 2,
  parameter parMode_e          W_MODE      = PAR_EVEN,
  parameter parMode_e          R_MODE      = PAR_ODD,
  parameter int                PIPE_W      = 4,
  parameter logic [PIPE_W-1:0] PIPE_MASK   = 4'b0101
) (
  input  logic                     aclk,
  input  logic                     aresetn,
  input  parStrobes_t              strobes,
  input  logic [DATA_WIDTH-1:0]    wData,
  input  logic [DATA_WIDTH/8-1:0]  wStrb,
  input  logic [WUSER_WIDTH-1:0]   wUser,
  input  logic [DATA_WIDTH-1:0]    rData,
  input  logic [RUSER_WIDTH-1:0]   rUser,
  output logic                     wErr,
  output logic                     rErr
);

  localparam int   LANES = DATA_WIDTH / 8;
  localparam logic W_ODD = (W_MODE == PAR_ODD);
  localparam logic R_ODD = (R_MODE == PAR_ODD);
  localparam logic W_ON  = (W_MODE != PAR_OFF);
  localparam logic R_ON  = (R_MODE != PAR_OFF);

  logic [LANES-1:0] wLaneBad;
  logic [LANES-1:0] rLaneBad;
  logic             wBeatErr;
  logic             rBeatErr;
  logic             unusedUserBits;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wLaneBad[g] = wStrb[g] &
                         ((^wData[8*g +: 8]) ^ wUser[g*W_STRIDE] ^ W_ODD);
    assign rLaneBad[g] = (^rData[8*g +: 8]) ^ rUser[g*R_STRIDE] ^ R_ODD;
  end

  // Lanes not at a stride index are deliberately ignored.
  assign unusedUserBits = ^{wUser, rUser};

  assign wBeatErr = strobes.wFire & ((W_ON & (|wLaneBad)) | strobes.wForce);
  assign rBeatErr = strobes.rFire & ((R_ON & (|rLaneBad)) | strobes.rForce);

  parity_pipe #(
    .PIPE_W   (PIPE_W),
    .PIPE_MASK(PIPE_MASK)
  ) u_wPipe (
    .aclk   (aclk),
    .aresetn(aresetn),
    .advance(strobes.advance),
    .din    (wBeatErr),
    .dout   (wErr)
  );

  parity_pipe #(
    .PIPE_W   (PIPE_W),
    .PIPE_MASK(PIPE_MASK)
  ) u_rPipe (
    .aclk   (aclk),
    .aresetn(aresetn),
    .advance(strobes.advance),
    .din    (rBeatErr),
    .dout   (rErr)
  );

endmodule

// File: rtl/axi_beat_parity_check.sv
module axi_beat_parity_check
  import axi_parity_pkg::*;
#(
  parameter int                DATA_WIDTH  = 32,
  parameter int                WUSER_WIDTH = 4,
  parameter int                RUSER_WIDTH = 8,
  parameter int                W_STRIDE    = 1,
  parameter int                R_STRIDE    = 2,
  parameter parMode_e          W_MODE      = PAR_EVEN,
  parameter parMode_e          R_MODE      = PAR_ODD,
  parameter int                PIPE_W      = 4,
  parameter logic [PIPE_W-1:0] PIPE_MASK   = 4'b0101
) (
  input  logic                     aclk,
  input  logic                     aclken,
  input  logic                     aresetn,
  input  logic [DATA_WIDTH-1:0]    wData,
  input  logic [DATA_WIDTH/8-1:0]  wStrb,
  input  logic [WUSER_WIDTH-1:0]   wUser,
  input  logic                     wValid,
  input  logic                     wReady,
  input  logic [DATA_WIDTH-1:0]    rData,
  input  logic [RUSER_WIDTH-1:0]   rUser,
  input  logic                     rValid,
  input  logic                     rReady,
  input  logic                     wInject,
  input  logic                     rInject,
  output logic                     wParityErr,
  output logic                     rParityErr
);

  localparam int   LANES   = DATA_WIDTH / 8;
  localparam int   LATENCY = $countones(PIPE_MASK);
  localparam logic R_OFF   = (R_MODE == PAR_OFF);
  localparam logic W_OFF   = (W_MODE == PAR_OFF);

  if (DATA_WIDTH % 8 != 0) begin : g_badData
    $error("DATA_WIDTH must be a multiple of 8");
  end
  if (WUSER_WIDTH < (LANES - 1) * W_STRIDE + 1) begin : g_badWUser
    $error("WUSER_WIDTH too small for the write stride");
  end
  if (RUSER_WIDTH < (LANES - 1) * R_STRIDE + 1) begin : g_badRUser
    $error("RUSER_WIDTH too small for the read stride");
  end

  parStrobes_t strobes;

  parity_ctrl u_ctrl (
    .aresetn(aresetn),
    .aclken (aclken),
    .wValid (wValid),
    .wReady (wReady),
    .rValid (rValid),
    .rReady (rReady),
    .wInject(wInject),
    .rInject(rInject),
    .strobes(strobes)
  );

  parity_dp #(
    .DATA_WIDTH (DATA_WIDTH),
    .WUSER_WIDTH(WUSER_WIDTH),
    .RUSER_WIDTH(RUSER_WIDTH),
    .W_STRIDE   (W_STRIDE),
    .R_STRIDE   (R_STRIDE),
    .W_MODE     (W_MODE),
    .R_MODE     (R_MODE),
    .PIPE_W     (PIPE_W),
    .PIPE_MASK  (PIPE_MASK)
  ) u_dp (
    .aclk   (aclk),
    .aresetn(aresetn),
    .strobes(strobes),
    .wData  (wData),
    .wStrb  (wStrb),
    .wUser  (wUser),
    .rData  (rData),
    .rUser  (rUser),
    .wErr   (wParityErr),
    .rErr   (rParityErr)
  );

endmodule

// File: rtl/axi_beat_parity_check_chk.sv
module axi_beat_parity_check_chk #(
  parameter int   LATENCY = 2,
  parameter logic R_OFF   = 1'b0,
  parameter logic W_OFF   = 1'b0
) (
  input logic aclk,
  input logic aclken,
  input logic aresetn,
  input logic wValid,
  input logic wReady,
  input logic rValid,
  input logic rReady,
  input logic wInject,
  input logic rInject,
  input logic wParityErr,
  input logic rParityErr
);

  always @(posedge aclk) begin
    if (!aresetn) begin
      AST_RESET_QUIET: assert (!wParityErr && !rParityErr); // R9
    end
  end

  if (LATENCY > 0) begin : g_piped
    AST_W_FREEZE: assert property (@(posedge aclk) disable iff (!aresetn)
      !aclken |=> $stable(wParityErr)); // R8
    AST_R_FREEZE: assert property (@(posedge aclk) disable iff (!aresetn)
      !aclken |=> $stable(rParityErr)); // R8
  end else begin : g_direct
    AST_W_ONLY_ON_BEAT: assert property (@(posedge aclk) disable iff (!aresetn)
      wParityErr |-> (wValid && wReady && aclken)); // R4
    AST_R_ONLY_ON_BEAT: assert property (@(posedge aclk) disable iff (!aresetn)
      rParityErr |-> (rValid && rReady && aclken)); // R4
    AST_W_INJECT_WINS: assert property (@(posedge aclk) disable iff (!aresetn)
      (wValid && wReady && aclken && wInject) |-> wParityErr); // R5
    AST_R_INJECT_WINS: assert property (@(posedge aclk) disable iff (!aresetn)
      (rValid && rReady && aclken && rInject) |-> rParityErr); // R5
    if (R_OFF) begin : g_rOff
      AST_R_OFF_QUIET: assert property (@(posedge aclk) disable iff (!aresetn)
        rParityErr |-> rInject); // R6
    end
    if (W_OFF) begin : g_wOff
      AST_W_OFF_QUIET: assert property (@(posedge aclk) disable iff (!aresetn)
        wParityErr |-> wInject); // R6
    end
  end

endmodule

bind axi_beat_parity_check axi_beat_parity_check_chk #(
  .LATENCY(LATENCY),
  .R_OFF  (R_OFF),
  .W_OFF  (W_OFF)
) u_chk (
  .aclk      (aclk),
  .aclken    (aclken),
  .aresetn   (aresetn),
  .wValid    (wValid),
  .wReady    (wReady),
  .rValid    (rValid),
  .rReady    (rReady),
  .wInject   (wInject),
  .rInject   (rInject),
  .wParityErr(wParityErr),
  .rParityErr(rParityErr)
);

// File: tb/axi_beat_parity_check_bench.sv
`timescale 1ns/1ps
module axi_beat_parity_check_bench;
  import axi_parity_pkg::*;

  logic        aclk = 1'b0;
  logic        aclken;
  logic        aresetn;
  logic [31:0] wData;
  logic [3:0]  wStrb;
  logic [3:0]  wUser;
  logic        wValid, wReady;
  logic [31:0] rData;
  logic [7:0]  rUser;
  logic        rValid, rReady;
  logic        wInject, rInject;
  logic        aWErr, aRErr, bWErr, bRErr;

  int checks = 0;
  int errors = 0;
  bit shAw [2];
  bit shAr [2];

  always #5 aclk = ~aclk;

  // Instance A: write even, read odd, mask 0101 -> latency 2
  axi_beat_parity_check u_axi_beat_parity_check (
    .aclk(aclk), .aclken(aclken), .aresetn(aresetn),
    .wData(wData), .wStrb(wStrb), .wUser(wUser), .wValid(wValid), .wReady(wReady),
    .rData(rData), .rUser(rUser), .rValid(rValid), .rReady(rReady),
    .wInject(wInject), .rInject(rInject),
    .wParityErr(aWErr), .rParityErr(aRErr)
  );

  // Instance B: write odd, read disabled, no pipeline
  axi_beat_parity_check #(
    .W_MODE(PAR_ODD), .R_MODE(PAR_OFF), .PIPE_MASK(4'b0000)
  ) u_axi_beat_parity_check_b (
    .aclk(aclk), .aclken(aclken), .aresetn(aresetn),
    .wData(wData), .wStrb(wStrb), .wUser(wUser), .wValid(wValid), .wReady(wReady),
    .rData(rData), .rUser(rUser), .rValid(rValid), .rReady(rReady),
    .wInject(wInject), .rInject(rInject),
    .wParityErr(bWErr), .rParityErr(bRErr)
  );

  function automatic bit calcBad(input logic [31:0] d, input logic [7:0] user,
                                 input int stride, input logic [3:0] mask, input bit odd);
    bit b = 1'b0;
    for (int i = 0; i < 4; i++)
      if (mask[i] && (((^d[8*i +: 8]) ^ user[i*stride] ^ odd) == 1'b1)) b = 1'b1;
    return b;
  endfunction

  function automatic logic [7:0] mkUser(input logic [31:0] d, input logic [3:0] corrupt,
                                        input int stride, input bit odd, input logic [7:0] junk);
    logic [7:0] u = junk;
    for (int i = 0; i < 4; i++)
      u[i*stride] = (^d[8*i +: 8]) ^ odd ^ corrupt[i];
    return u;
  endfunction

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive one cycle's inputs at the falling edge, then compare outputs.
  task automatic step(input string tag);
    bit wFire, rFire, expAw, expAr, expBw, expBr;
    #1;
    wFire = aresetn & aclken & wValid & wReady;
    rFire = aresetn & aclken & rValid & rReady;
    expAw = wFire & (calcBad(wData, {4'b0, wUser}, 1, wStrb, 1'b0) | wInject);
    expAr = rFire & (calcBad(rData, rUser, 2, 4'hF, 1'b1) | rInject);
    expBw = wFire & (calcBad(wData, {4'b0, wUser}, 1, wStrb, 1'b1) | wInject);
    expBr = rFire & rInject;
    if (!aresetn) begin
      shAw[0] = 0; shAw[1] = 0; shAr[0] = 0; shAr[1] = 0;
    end
    check({tag, " R7"}, "A write", aWErr, shAw[1]);
    check({tag, " R7"}, "A read", aRErr, shAr[1]);
    check(tag, "B write", bWErr, expBw);
    check({tag, " R6"}, "B read", bRErr, expBr);
    if (aresetn && aclken) begin
      shAw[1] = shAw[0]; shAw[0] = expAw;
      shAr[1] = shAr[0]; shAr[0] = expAr;
    end
    @(negedge aclk);
  endtask

  task automatic beat(input logic [3:0] wCor, input logic [3:0] rCor, input logic [3:0] strb,
                      input bit wv, input bit wr, input bit rv, input bit rr,
                      input bit wi, input bit ri, input bit cen);
    logic [7:0] wu;
    wData   = $urandom;
    rData   = $urandom;
    wu      = mkUser(wData, wCor, 1, 1'b0, 8'h00);
    wUser   = wu[3:0];
    rUser   = mkUser(rData, rCor, 2, 1'b1, 8'($urandom));
    wStrb   = strb;
    wValid  = wv; wReady = wr; rValid = rv; rReady = rr;
    wInject = wi; rInject = ri; aclken = cen;
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    aresetn = 1'b0;
    beat(4'hF, 4'hF, 4'hF, 1, 1, 1, 1, 1, 1, 1);
    @(negedge aclk);

    // R9: reset holds outputs low despite bad beats and injection
    for (int n = 0; n < 4; n++) begin
      beat(4'hF, 4'hF, 4'hF, 1, 1, 1, 1, 1, 1, 1);
      step("R9 reset");
    end
    aresetn = 1'b1;
    for (int n = 0; n < 4; n++) begin
      beat(4'h0, 4'h0, 4'hF, 0, 0, 0, 0, 0, 0, 1);
      step("R9 release");
    end

    // R1 R2 R3: sweep strobes and corruption patterns, every beat handshaken
    for (int n = 0; n < 1024; n++) begin
      logic [9:0] v = 10'(n);
      beat(v[7:4], 4'($urandom), v[3:0], 1, 1, 1, 1, 0, 0, 1);
      step("R1 R2 R3 sweep");
    end

    // R1 R2: single-lane walk, one corrupted lane with only its strobe, then others
    for (int lane = 0; lane < 4; lane++) begin
      for (int s = 0; s < 2; s++) begin
        logic [3:0] one = 4'(1 << lane);
        beat(one, one, s ? ~one : one, 1, 1, 1, 1, 0, 0, 1);
        step("R1 R2 lane walk");
      end
    end

    // R4: all valid/ready combinations with bad parity
    for (int n = 0; n < 256; n++) begin
      logic [7:0] v = 8'(n);
      beat(4'($urandom), 4'($urandom), 4'hF, v[0], v[1], v[2], v[3], 0, 0, 1);
      step("R4 handshake");
    end

    // R5 R6: injection with random parity and handshakes
    for (int n = 0; n < 256; n++) begin
      logic [7:0] v = 8'(n);
      beat(4'($urandom), 4'($urandom), 4'($urandom), v[0] | v[4], v[1] | v[5],
           v[0] | v[6], v[1] | v[7], v[2], v[3], 1);
      step("R5 R6 inject");
    end

    // R8: random clock enable with random traffic
    for (int n = 0; n < 600; n++) begin
      logic [7:0] v = 8'($urandom);
      beat(4'($urandom), 4'($urandom), 4'($urandom), v[0], v[1], v[2], v[3],
           v[4] & v[5], v[6] & v[7], 1'($urandom));
      step("R8 clock enable");
    end

    // R4: idle tail, pulses must drain and not stick
    for (int n = 0; n < 6; n++) begin
      beat(4'hF, 4'hF, 4'hF, 0, 1, 1, 0, 0, 0, 1);
      step("R4 idle tail");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule